// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port attached to a simple memory-mapped byte bus. It holds a direction register and an output data register, drives a per-line output enable and pad output, and samples the input pads through a two-stage synchronizer. Software reaches it through one-cycle access strobes that carry an address, a write flag and a write byte.

Accesses below the direction register fall in a data window, where address bits [9:2] act as a per-line mask. Software can therefore set, clear or read any subset of lines in a single access, with no read-modify-write sequence. A data write only changes lines that are already outputs. To put a value on a line that was an input, software must first make it an output and then write the value again. The interrupt offsets above the direction register belong to a separate detection block. In this port they read as zero and ignore writes.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the direction register and the output data register are both 0x00. As a result, pin_oe and pin_out are both 0x00.
- R2: A write at offset 0x400 loads the direction register, and a read at that offset returns it. Bit n set to 1 makes line n an output. pin_oe equals the direction register at all times.
- R3: A write at an offset below 0x400 uses address bits [9:2] as a mask, where bit n enables line n. Only masked lines take the new write-data bit. Every other output data bit keeps its value.
- R4: A data write has no effect on a line whose direction bit is 0. Switching that line to output afterwards drives the value the line held before, not the ignored write.
- R5: A read at an offset below 0x400 returns the line values ANDed with the address mask, so unmasked bits read as 0.
- R6: In a data read, an output line returns its output data bit. An input line returns pin_in delayed through two flip-flops, so a pin change becomes visible only from the second clock edge after it.
- R7: Reads at any offset other than the data window and 0x400 return 0x00. Writes at those offsets change no register.
- R8: pin_out equals the output data register on every line.
- R9: Read data is registered on the clock edge that ends a read strobe. It holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| pin_in | input | 8 | Pad input values, asynchronous |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The assertions assume that bus_sel, bus_we, bus_addr and bus_wdata change only away from the rising clock edge. They also assume that each strobe lasts exactly one cycle and that all bus inputs are known while bus_sel is high. The bench drives every bus signal on the falling edge and returns bus_sel to 0 after each access. It also changes pin_in only on a falling edge, so the synchronizer's latency can be counted in whole cycles.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DIR_OFFSET = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pin_out,
  output logic [7:0]        pin_oe
);
  localparam int LANES = 8;
  localparam int MASK_LSB = 2;

  logic [LANES-1:0] dir_q, out_q, sync1_q, sync2_q;
  logic [LANES-1:0] lane_mask, lane_val, rd_next, wr_en;
  logic             hit_data, hit_dir, do_wr, do_rd;

  assign hit_data  = bus_addr < DIR_OFFSET;
  assign hit_dir   = bus_addr == DIR_OFFSET;
  assign lane_mask = bus_addr[MASK_LSB +: LANES];
  assign do_wr     = bus_sel & bus_we;
  assign do_rd     = bus_sel & ~bus_we;
  assign wr_en     = lane_mask & dir_q;
  assign lane_val  = (dir_q & out_q) | (~dir_q & sync2_q);

  always_comb begin
    if (hit_data)     rd_next = lane_val & lane_mask;
    else if (hit_dir) rd_next = dir_q;
    else              rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (do_wr) begin
      if (hit_dir)  dir_q <= bus_wdata;
      if (hit_data) out_q <= (out_q & ~wr_en) | (bus_wdata & wr_en);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (do_rd) bus_rdata <= rd_next;
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DIR_OFFSET = 'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        pin_in,
  input logic [7:0]        pin_out,
  input logic [7:0]        pin_oe
);
  logic [7:0] amask;
  logic       in_win, at_dir;
  assign amask  = bus_addr[2 +: 8];
  assign in_win = bus_addr < DIR_OFFSET;
  assign at_dir = bus_addr == DIR_OFFSET;

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && at_dir) |=> (pin_oe == $past(bus_wdata)));

  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && at_dir) |=> $stable(pin_oe));

  assert_unmasked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && in_win) |=> ((pin_out & ~$past(amask)) == ($past(pin_out) & ~$past(amask))));

  assert_input_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we) |=> ((pin_out & ~$past(pin_oe)) == ($past(pin_out) & ~$past(pin_oe))));

  assert_read_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && in_win) |=> ((bus_rdata & ~$past(amask)) == 8'h00));

  assert_undef_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !in_win && !at_dir) |=> (bus_rdata == 8'h00));

  assert_undef_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !in_win && !at_dir) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFFSET)) u_chk (.*);

// File: tb/tb_gpio_mask_port.sv
module tb_gpio_mask_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, pin_in = '0;
  logic [7:0]  bus_rdata, pin_out, pin_oe;
  int          n_chk = 0, n_err = 0;
  logic [7:0]  rv;

  always #2.5 clk = ~clk;

  gpio_mask_port dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic t_reset;
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    rd(12'h400, rv); check("R1 dir", rv, 8'h00);
    rd(12'h3FC, rv); check("R1 data", rv, 8'h00);
  endtask

  task automatic t_dir;
    wr(12'h400, 8'hF0);
    check("R2 oe", pin_oe, 8'hF0);
    rd(12'h400, rv); check("R2 readback", rv, 8'hF0);
  endtask

  task automatic t_masked_write;
    wr(12'h3FC, 8'hA0);
    check("R8 out all", pin_out, 8'hA0);
    wr(12'h1 << 9, 8'h00);
    check("R3 clear bit7", pin_out, 8'h20);
    wr(12'h1 << 6, 8'hFF);
    check("R3 set bit4", pin_out, 8'h30);
    wr(12'h000, 8'hFF);
    check("R3 zero mask", pin_out, 8'h30);
  endtask

  task automatic t_input_write;
    wr(12'h1 << 2, 8'h01);
    check("R4 input line ignored", pin_out, 8'h30);
    wr(12'h400, 8'hF1);
    check("R4 after switch", pin_out, 8'h30);
    wr(12'h1 << 2, 8'h01);
    check("R4 rewrite", pin_out, 8'h31);
  endtask

  task automatic t_read;
    pin_in = 8'h0E;
    repeat (3) @(posedge clk);
    rd(12'h3FC, rv); check("R6 mixed", rv, 8'h3F);
    rd(12'h1 << 3, rv); check("R5 single bit1", rv, 8'h02);
    rd(12'h1 << 9, rv); check("R5 single bit7", rv, 8'h00);
    rd(12'h0F0, rv); check("R5 mask 3C", rv, 8'h3C);
  endtask

  task automatic t_sync;
    @(negedge clk); pin_in = 8'h00;
    rd(12'h3FC, rv); check("R6 before sync", rv, 8'h3F);
    rd(12'h3FC, rv); check("R6 after sync", rv, 8'h31);
  endtask

  task automatic t_undef;
    wr(12'h404, 8'hFF);
    wr(12'h41C, 8'h00);
    check("R7 oe kept", pin_oe, 8'hF1);
    check("R7 out kept", pin_out, 8'h31);
    rd(12'h410, rv); check("R7 read zero", rv, 8'h00);
  endtask

  task automatic t_hold;
    rd(12'h400, rv);
    wr(12'h3FC, 8'h00);
    repeat (2) @(posedge clk); #1;
    check("R9 rdata held", bus_rdata, 8'hF1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset; t_dir; t_masked_write; t_input_write; t_read; t_sync; t_undef; t_hold;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule